// File: doc/BRIEF.md
# ADC Test Pattern Checker

This block sits after the capture and word-assembly logic of a converter receive path. It checks each 14-bit sample against the test pattern that the converter has been told to send. In counting mode, each sample must be one more than the sample before it. In walking-bit mode, the word must carry exactly one set bit, at an index that software selects. When a sample is wrong, the block flags it for one cycle and counts it. It also says what kind of fault the sample looks like, so that a capture problem can be narrowed down without a logic analyser.

Two faults are common when a double-data-rate capture is first brought up. One is a clock polarity error, which exchanges every even bit with its odd neighbour. The other is a bit that lands in the wrong lane. The diagnostic output names both, and for a single stray bit it gives the index where that bit landed. A lock output rises once a run of good samples has been seen, which gives a simple go/no-go signal while capture delays are swept.

Top module: `adc_pattern_checker`

## Requirements
- R1: After reset, err_pulse_o, lock_o, err_count_o, diag_kind_o and diag_pos_o are all zero.
- R2: With mode_i = 0 (counting), the first valid sample after reset, or the first after a switch into counting mode, is taken as a seed. It is not flagged. Each later valid sample must equal the previous valid sample plus one, modulo 2^14, so 16383 followed by 0 is correct.
- R3: With mode_i = 1 (walking bit), the expected word has only bit bit_idx_i set: index 0 expects 0x0001, index 1 expects 0x0002, and so on. An index of 14 or more expects the all-zero word.
- R4: A valid sample that differs from the expected word drives err_pulse_o high in the cycle after the clock edge that took the sample. Cycles with sample_vld_i low never raise err_pulse_o and leave the expected value, the lock state and the diagnostic outputs unchanged.
- R5: A mismatch re-seeds the counting check: after a wrong sample S, the next expected value is S + 1.
- R6: lock_o rises after the edge that takes the 16th consecutive correct checked sample, and it stays high while samples remain correct. A mismatch clears it in the same cycle that err_pulse_o rises. A valid sample whose mode differs from that of the previous valid sample restarts the run.
- R7: diag_kind_o is updated on every valid sample and held otherwise. Its codes are: 0 for a match or a seed; 1 when the sample equals the expected word with bits 2k and 2k+1 exchanged for every k; 2 when the sample has exactly one set bit but is wrong; 3 for any other mismatch. Code 1 takes priority over code 2.
- R8: diag_pos_o gives the index of the single set bit when diag_kind_o is 2, and is 0 otherwise.
- R9: err_count_o increases by one for each flagged sample and saturates at 65535.
- R10: A high err_clr_i clears err_count_o to 0 at the next clock edge. A clear takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 14 | Reassembled converter sample |
| sample_vld_i | input | 1 | sample_i holds a new sample this cycle |
| mode_i | input | 1 | 0 = counting check, 1 = walking-bit check |
| bit_idx_i | input | 4 | Expected set-bit index in walking-bit mode |
| err_clr_i | input | 1 | Synchronous clear of the error counter |
| err_pulse_o | output | 1 | One-cycle flag for a wrong sample |
| lock_o | output | 1 | Run of correct samples reached |
| err_count_o | output | 16 | Saturating count of wrong samples |
| diag_kind_o | output | 2 | Mismatch classification of the last valid sample |
| diag_pos_o | output | 4 | Set-bit index for a stray single bit |

## Verification
If the stored counting value is corrupted, the next valid sample is flagged, lock_o drops, and diag_kind_o changes from zero, all one cycle after that sample. A run counter that is off shows up as lock_o rising one sample early or late around the 16th good sample. A wrong priority or a bad pair-exchange mapping shows up at once as the wrong code on diag_kind_o. That is checked for walking bits at even and odd indices, and for counting values that differ from their swapped image. Counter faults appear on err_count_o at the edge after the first flagged sample, and at the saturation and clear boundaries.

// File: rtl/tpc_pkg.sv
// Package: shared mode and diagnostic encodings for the test pattern checker.
// Assumes: the mode is a single-bit select; diagnostic codes fit in 2 bits.
package tpc_pkg;

    typedef enum logic {
        MODE_RAMP = 1'b0,
        MODE_WALK = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        DIAG_NONE      = 2'd0,
        DIAG_SWAP      = 2'd1,
        DIAG_MISPLACED = 2'd2,
        DIAG_OTHER     = 2'd3
    } diag_e;

endpackage

// File: rtl/tpc_expect.sv
// Module: tpc_expect
// Builds the word the current sample should equal. In counting mode it
// stores the last valid sample plus one. In walking mode it decodes the bit
// index into a one-hot word. It also reports whether this sample is checked,
// and whether a change of mode restarts the good-sample run.
// Assumes: sample_i is only meaningful when vld_i is high.
module tpc_expect
    import tpc_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int IDX_W    = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic                mode_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SAMPLE_W-1:0] expected_o,
    output logic                check_en_o,
    output logic                restart_o
);

    logic [SAMPLE_W-1:0] ramp_next_q;
    logic                seeded_q;
    mode_e               mode_last_q;
    mode_e               mode_c;
    logic [SAMPLE_W-1:0] walk_word;

    assign mode_c = mode_e'(mode_i);

    // One-hot decode of the walking-bit index; indices past the top give zero
    for (genvar b = 0; b < SAMPLE_W; b++) begin : g_walk
        assign walk_word[b] = (idx_i == IDX_W'(b));
    end

    // Track the next counting value, the seed flag and the mode of the last sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp_next_q <= '0;
            seeded_q    <= 1'b0;
            mode_last_q <= MODE_RAMP;
        end else if (vld_i) begin
            ramp_next_q <= sample_i + 1'b1;
            seeded_q    <= 1'b1;
            mode_last_q <= mode_c;
        end
    end

    // Select the expected word and the check qualifiers for this sample
    always_comb begin
        expected_o = (mode_c == MODE_WALK) ? walk_word : ramp_next_q;
        check_en_o = (mode_c == MODE_WALK) ||
                     (seeded_q && (mode_last_q == MODE_RAMP));
        restart_o  = seeded_q && (mode_c != mode_last_q);
    end

endmodule

// File: rtl/tpc_classify.sv
// Module: tpc_classify
// Compares an observed word with the expected word and names the kind of
// mismatch: a pair-exchanged image, a single stray bit (with its index),
// or anything else. A pair exchange takes priority over a stray bit.
// Assumes: purely combinational; the caller registers the results.
module tpc_classify
    import tpc_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int IDX_W    = $clog2(SAMPLE_W)
) (
    input  logic [SAMPLE_W-1:0] obs_i,
    input  logic [SAMPLE_W-1:0] exp_i,
    output logic                mismatch_o,
    output diag_e               kind_o,
    output logic [IDX_W-1:0]    pos_o
);

    localparam int ONES_W = $clog2(SAMPLE_W + 1);

    logic [SAMPLE_W-1:0] exp_swapped;
    logic [ONES_W-1:0]   ones;
    logic [IDX_W-1:0]    set_pos;

    // Exchange each even bit with its odd neighbour; an unpaired top bit stays put
    for (genvar b = 0; b < SAMPLE_W; b++) begin : g_swap
        if ((b % 2) == 0 && (b + 1) < SAMPLE_W) begin : g_even
            assign exp_swapped[b] = exp_i[b+1];
        end else if ((b % 2) == 1) begin : g_odd
            assign exp_swapped[b] = exp_i[b-1];
        end else begin : g_lone
            assign exp_swapped[b] = exp_i[b];
        end
    end

    // Count the set bits of the observed word and find the highest one
    always_comb begin
        ones    = '0;
        set_pos = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (obs_i[i]) begin
                ones    = ones + 1'b1;
                set_pos = IDX_W'(i);
            end
        end
    end

    // Pick the mismatch kind in priority order
    always_comb begin
        mismatch_o = (obs_i != exp_i);
        pos_o      = '0;
        if (!mismatch_o) begin
            kind_o = DIAG_NONE;
        end else if (obs_i == exp_swapped) begin
            kind_o = DIAG_SWAP;
        end else if (ones == ONES_W'(1)) begin
            kind_o = DIAG_MISPLACED;
            pos_o  = set_pos;
        end else begin
            kind_o = DIAG_OTHER;
        end
    end

endmodule

// File: rtl/tpc_lock.sv
// Module: tpc_lock
// Counts consecutive correct checked samples, saturating at the lock
// threshold, and raises lock once the threshold is reached. A mismatch or a
// mode restart empties the run. Seed samples leave the run where it is.
// Assumes: qualifiers are only acted on when vld_i is high.
module tpc_lock #(
    parameter int LOCK_COUNT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic check_en_i,
    input  logic restart_i,
    input  logic mismatch_i,
    output logic lock_o
);

    localparam int STREAK_W = $clog2(LOCK_COUNT + 1);
    localparam logic [STREAK_W-1:0] STREAK_MAX = STREAK_W'(LOCK_COUNT);

    logic [STREAK_W-1:0] streak_q;
    logic [STREAK_W-1:0] streak_base;
    logic [STREAK_W-1:0] streak_nxt;
    logic                lock_q;

    // Next run length from the restart, check and mismatch qualifiers
    always_comb begin
        streak_base = restart_i ? '0 : streak_q;
        streak_nxt  = streak_base;
        if (check_en_i) begin
            if (mismatch_i) begin
                streak_nxt = '0;
            end else if (streak_base != STREAK_MAX) begin
                streak_nxt = streak_base + 1'b1;
            end
        end
    end

    // Hold the run length and the lock flag, moving only on valid samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak_q <= '0;
            lock_q   <= 1'b0;
        end else if (vld_i) begin
            streak_q <= streak_nxt;
            lock_q   <= (streak_nxt == STREAK_MAX);
        end
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/tpc_errcnt.sv
// Module: tpc_errcnt
// Saturating error counter with a synchronous clear that beats an increment.
// Assumes: inc_i is at most one per cycle.
module tpc_errcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] count_q;

    // Clear, or step up unless already at the maximum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i && (count_q != '1)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/adc_pattern_checker.sv
// Module: adc_pattern_checker (top)
// Checks reassembled converter samples against a counting pattern or a
// walking single bit. Each wrong sample is flagged for one cycle and counted,
// a lock flag is kept, and each valid sample is classified. All outputs are
// registered and settle one cycle after the edge that takes a sample.
// Assumes: one sample per cycle at most; rst_n is synchronous and active low.
module adc_pattern_checker
    import tpc_pkg::*;
#(
    parameter int SAMPLE_W   = 14,
    parameter int LOCK_COUNT = 16,
    parameter int ERR_CNT_W  = 16,
    parameter int IDX_W      = $clog2(SAMPLE_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SAMPLE_W-1:0]  sample_i,
    input  logic                 sample_vld_i,
    input  logic                 mode_i,
    input  logic [IDX_W-1:0]     bit_idx_i,
    input  logic                 err_clr_i,
    output logic                 err_pulse_o,
    output logic                 lock_o,
    output logic [ERR_CNT_W-1:0] err_count_o,
    output logic [1:0]           diag_kind_o,
    output logic [IDX_W-1:0]     diag_pos_o
);

    logic [SAMPLE_W-1:0] expected;
    logic                check_en;
    logic                restart;
    logic                mismatch;
    diag_e               kind_c;
    logic [IDX_W-1:0]    pos_c;
    logic                flag_c;

    logic                err_pulse_q;
    diag_e               kind_q;
    logic [IDX_W-1:0]    pos_q;

    tpc_expect #(
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_expect (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (sample_vld_i),
        .mode_i     (mode_i),
        .idx_i      (bit_idx_i),
        .sample_i   (sample_i),
        .expected_o (expected),
        .check_en_o (check_en),
        .restart_o  (restart)
    );

    tpc_classify #(
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_classify (
        .obs_i      (sample_i),
        .exp_i      (expected),
        .mismatch_o (mismatch),
        .kind_o     (kind_c),
        .pos_o      (pos_c)
    );

    tpc_lock #(
        .LOCK_COUNT (LOCK_COUNT)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (sample_vld_i),
        .check_en_i (check_en),
        .restart_i  (restart),
        .mismatch_i (mismatch),
        .lock_o     (lock_o)
    );

    // A sample is in error only when it is valid, checked and different
    assign flag_c = sample_vld_i && check_en && mismatch;

    tpc_errcnt #(
        .CNT_W (ERR_CNT_W)
    ) u_errcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (flag_c),
        .clr_i   (err_clr_i),
        .count_o (err_count_o)
    );

    // Register the error flag and the diagnostic of each valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse_q <= 1'b0;
            kind_q      <= DIAG_NONE;
            pos_q       <= '0;
        end else begin
            err_pulse_q <= flag_c;
            if (sample_vld_i) begin
                kind_q <= check_en ? kind_c : DIAG_NONE;
                pos_q  <= check_en ? pos_c  : '0;
            end
        end
    end

    assign err_pulse_o = err_pulse_q;
    assign diag_kind_o = kind_q;
    assign diag_pos_o  = pos_q;

endmodule

// File: rtl/tpc_checker.sv
// Module: tpc_checker
// Assertion set for adc_pattern_checker, attached with the bind below.
// Assumes: the same parameters as the bound instance.
module tpc_checker
    import tpc_pkg::*;
#(
    parameter int ERR_CNT_W = 16,
    parameter int IDX_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_vld_i,
    input logic                 err_clr_i,
    input logic                 err_pulse_o,
    input logic                 lock_o,
    input logic [ERR_CNT_W-1:0] err_count_o,
    input logic [1:0]           diag_kind_o,
    input logic [IDX_W-1:0]     diag_pos_o
);

    localparam logic [ERR_CNT_W-1:0] CNT_MAX = '1;

    // R4: an error flag always follows a valid sample
    a_r4_pulse_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> $past(sample_vld_i));

    // R4: idle cycles leave lock and diagnostic untouched
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_i |=> ($stable(lock_o) && $stable(diag_kind_o) && $stable(diag_pos_o)));

    // R6: a flagged sample never coexists with lock
    a_r6_error_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> !lock_o);

    // R6: lock only rises after a valid sample
    a_r6_lock_rise_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(sample_vld_i));

    // R7: a flagged sample carries a non-zero diagnostic
    a_r7_flag_has_kind: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> (diag_kind_o != DIAG_NONE));

    // R8: the position is zero unless a stray single bit was seen
    a_r8_pos_only_misplaced: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_kind_o != DIAG_MISPLACED) |-> (diag_pos_o == '0));

    // R9: the counter holds at its maximum
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_count_o == CNT_MAX) && !err_clr_i) |=> (err_count_o == CNT_MAX));

    // R9: without a clear the counter moves by zero or one
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr_i |=> ((err_count_o == $past(err_count_o)) ||
                        (err_count_o == ERR_CNT_W'($past(err_count_o) + 1'b1))));

    // R10: a clear empties the counter at the next edge
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_i |=> (err_count_o == '0));

endmodule

bind adc_pattern_checker tpc_checker #(
    .ERR_CNT_W (ERR_CNT_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_vld_i (sample_vld_i),
    .err_clr_i    (err_clr_i),
    .err_pulse_o  (err_pulse_o),
    .lock_o       (lock_o),
    .err_count_o  (err_count_o),
    .diag_kind_o  (diag_kind_o),
    .diag_pos_o   (diag_pos_o)
);

// File: tb/adc_pattern_checker_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one cycle of stimulus, models the
// requirements and queues the expected outputs; the monitor compares them at
// the following falling edge.
module adc_pattern_checker_tb;

    localparam int W     = 14;
    localparam int IW    = 4;
    localparam int CW    = 16;
    localparam int LOCKN = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  sample_i = '0;
    logic          sample_vld_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [IW-1:0] bit_idx_i = '0;
    logic          err_clr_i = 1'b0;
    logic          err_pulse_o;
    logic          lock_o;
    logic [CW-1:0] err_count_o;
    logic [1:0]    diag_kind_o;
    logic [IW-1:0] diag_pos_o;

    always #2.5 clk = ~clk;

    adc_pattern_checker u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (sample_i),
        .sample_vld_i (sample_vld_i),
        .mode_i       (mode_i),
        .bit_idx_i    (bit_idx_i),
        .err_clr_i    (err_clr_i),
        .err_pulse_o  (err_pulse_o),
        .lock_o       (lock_o),
        .err_count_o  (err_count_o),
        .diag_kind_o  (diag_kind_o),
        .diag_pos_o   (diag_pos_o)
    );

    typedef struct packed {
        logic          err;
        logic          lock;
        logic [CW-1:0] cnt;
        logic [1:0]    kind;
        logic [IW-1:0] pos;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Reference state built from the requirements
    bit          m_seeded = 0;
    bit          m_mode_last = 0;
    logic [W-1:0] m_next = '0;
    int          m_streak = 0;
    bit          m_lock = 0;
    int          m_cnt = 0;
    int          m_kind = 0;
    int          m_pos = 0;

    function automatic logic [W-1:0] swap_pairs(input logic [W-1:0] x);
        return ((x & 14'h1555) << 1) | ((x & 14'h2AAA) >> 1);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Driver: one cycle of stimulus, then model the result and queue it
    task automatic drive(input bit vld, input logic [W-1:0] s, input bit mode,
                         input int idx, input bit clr, input string tag);
        logic [W-1:0] expw;
        bit chk, rst_run, err;
        item_t it;
        @(negedge clk);
        sample_vld_i = vld;
        sample_i     = s;
        mode_i       = mode;
        bit_idx_i    = IW'(idx);
        err_clr_i    = clr;
        @(posedge clk);
        chk     = mode || (m_seeded && !m_mode_last);
        rst_run = m_seeded && (mode != m_mode_last);
        if (mode) expw = (idx < W) ? (W'(1) << idx) : '0;
        else      expw = m_next;
        err = 0;
        if (vld) begin
            if (rst_run) m_streak = 0;
            if (!chk) begin
                m_kind = 0; m_pos = 0;
            end else begin
                err = (s != expw);
                m_pos = 0;
                if (!err) m_kind = 0;
                else if (s == swap_pairs(expw)) m_kind = 1;
                else if ($countones(s) == 1) begin
                    m_kind = 2;
                    for (int i = 0; i < W; i++) if (s[i]) m_pos = i;
                end else m_kind = 3;
                if (err) m_streak = 0;
                else if (m_streak < LOCKN) m_streak++;
            end
            m_lock      = (m_streak >= LOCKN);
            m_next      = s + 1'b1;
            m_seeded    = 1;
            m_mode_last = mode;
        end
        if (clr) m_cnt = 0;
        else if (err && m_cnt < 65535) m_cnt++;
        it.err  = err;
        it.lock = m_lock;
        it.cnt  = CW'(m_cnt);
        it.kind = 2'(m_kind);
        it.pos  = IW'(m_pos);
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each queued item away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "err_pulse(R4)", int'(err_pulse_o), int'(e.err));
                check(t, "lock(R6)",      int'(lock_o),      int'(e.lock));
                check(t, "count(R9)",     int'(err_count_o), int'(e.cnt));
                check(t, "kind(R7)",      int'(diag_kind_o), int'(e.kind));
                check(t, "pos(R8)",       int'(diag_pos_o),  int'(e.pos));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen on an idle cycle
        drive(0, '0, 0, 0, 0, "R1");
        // R2 / R6: seed then 16 correct counts; lock on the 16th
        drive(1, 14'd100, 0, 0, 0, "R2");
        for (int k = 1; k <= 16; k++) drive(1, W'(100 + k), 0, 0, 0, "R6");
        // R4: idle cycles hold state, then counting continues
        drive(0, 14'h3FFF, 0, 0, 0, "R4");
        drive(0, 14'h0000, 0, 0, 0, "R4");
        drive(1, 14'd117, 0, 0, 0, "R4");
        // R5: wrong value re-seeds, then counting across the wrap (R2)
        drive(1, 14'd16378, 0, 0, 0, "R5");
        for (int k = 1; k <= 18; k++) drive(1, W'(16378 + k), 0, 0, 0, "R2");
        // R7: pair-exchanged counting value: after 5 expect 6, send 9
        drive(1, 14'd5, 0, 0, 0, "R5");
        drive(1, 14'd9, 0, 0, 0, "R7");
        drive(1, 14'd10, 0, 0, 0, "R5");
        // R3 / R6: switch to walking mode, run restarts
        drive(1, 14'h0001, 1, 0, 0, "R3");
        drive(1, 14'h0020, 1, 5, 0, "R3");
        drive(1, 14'h2000, 1, 13, 0, "R3");
        drive(1, 14'h0000, 1, 14, 0, "R3");
        // R7: swapped lanes at an even and an odd index
        drive(1, 14'h0002, 1, 0, 0, "R7");
        drive(1, 14'h0004, 1, 3, 0, "R7");
        // R8: stray single bit and its index
        drive(1, 14'h0100, 1, 4, 0, "R8");
        drive(1, 14'h0001, 1, 14, 0, "R8");
        // R7: other mismatch
        drive(1, 14'h0003, 1, 0, 0, "R7");
        drive(0, 14'h0000, 1, 0, 0, "R4");
        // R6: back to counting: seed after mode change, then lock again
        drive(1, 14'd200, 0, 0, 0, "R6");
        for (int k = 1; k <= 17; k++) drive(1, W'(200 + k), 0, 0, 0, "R6");
        drive(1, 14'd0, 0, 0, 0, "R6");
        // R10: clear together with an error
        drive(1, 14'h0000, 1, 0, 1, "R10");
        // R9: drive errors until the counter saturates
        for (int k = 0; k < 65540; k++) drive(1, 14'h0000, 1, 2, 0, "R9");
        drive(0, 14'h0000, 1, 2, 1, "R10");
        drive(0, 14'h0000, 1, 2, 0, "R10");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule